// File: doc/BRIEF.md
# Machine-Cycle Sequencer with Idle and Power-Down Clock Control

This block derives the machine-cycle timing of an 8-bit controller core from the oscillator clock. Every oscillator period advances a two-half phase flag. Every second period advances a state number that runs from 1 to 6 and then wraps, so one machine cycle spans twelve oscillator periods. A one-period strobe marks the last half of state 6, which is the point where the core finishes a machine cycle.

Two low-power modes are requested by strobes from the core's power-control register. Both act only at a machine-cycle boundary. In idle, the core's clock enable drops while the sequencer and the peripheral enable keep running. Any interrupt ends idle at the next boundary. In power-down, the oscillator-run output drops and the sequencer parks at state 1, phase 1. An external or real-time-clock interrupt starts a fixed settling count, after which the core resumes at the start of state 1.

Top module: `mcpc_top`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), and right after it rises, the outputs are `state_num`=1, `phase2`=0, `cpu_en`=1, `periph_en`=1, `osc_run`=1 and `cycle_end`=0, and no mode request is pending.
- R2: While the sequencer runs, `phase2` toggles on every clock. `state_num` advances by one after each `phase2`=1 period, and wraps from 6 to 1, so a machine cycle is 12 clocks.
- R3: `cycle_end` is 1 exactly during state 6 with `phase2`=1, and only while `cpu_en` is 1. It is never high for two clocks in a row.
- R4: A one-clock pulse on `set_idle` or `set_pdown` is held pending and takes effect at the end of the current machine cycle. A pulse sampled on the state-6 phase-2 clock edge takes effect at that same boundary. Pulses are ignored while the block is not in run mode.
- R5: In idle, `cpu_en` is 0, while `periph_en` and `osc_run` stay 1 and the sequencer keeps counting.
- R6: In idle, any pulse on `ext_irq`, `rtc_irq` or `periph_irq` ends idle at the next machine-cycle end, or at that same end if the pulse is sampled on it. `cpu_en` returns to 1 with `state_num`=1 and `phase2`=0, and stays at 1 afterwards.
- R7: In power-down, `osc_run`, `cpu_en` and `periph_en` are 0, and the outputs hold state 1, phase 1. `periph_irq` has no effect.
- R8: In power-down, a pulse on either `ext_irq` bit or on `rtc_irq` starts a settling interval of exactly SETTLE_CYC clocks. During it, `osc_run` is 1, both enables are 0 and the outputs show state 1, phase 1. Run mode then resumes at state 1, phase 1.
- R9: When idle and power-down are both pending at a boundary, power-down is entered.
- R10: Reset ends idle, power-down and settling immediately and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator reference clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| set_idle | input | 1 | Idle request strobe from the power-control register |
| set_pdown | input | 1 | Power-down request strobe from the power-control register |
| ext_irq | input | N_EXT (2) | External interrupt requests |
| rtc_irq | input | 1 | Real-time-clock interrupt |
| periph_irq | input | 1 | Interrupt from timers or serial ports (wakes idle only) |
| state_num | output | 3 | Current state, 1 to 6 |
| phase2 | output | 1 | 0 in the first half of a state, 1 in the second |
| cycle_end | output | 1 | End-of-machine-cycle strobe |
| cpu_en | output | 1 | Core clock enable |
| periph_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator-run indication |

## Verification
The hardest situations to reach are the ones where an event lands exactly on the machine-cycle boundary. One is a request sampled on the state-6 phase-2 edge itself. The other is an idle wake arriving on that edge, which must end idle without waiting a further twelve clocks. The stimulus first synchronises to the outputs by waiting until state 6, phase 2 is shown. It then drives the pulse at that falling edge, so that the following rising edge is the boundary. A behavioural model of positions, modes and settling counts checks every clock, including a request written during idle that must leave no trace after the wake.

// File: rtl/mcpc_pkg.sv
package mcpc_pkg;

    // Operating modes of the clock controller
    typedef enum logic [1:0] {
        MD_RUN    = 2'd0,
        MD_IDLE   = 2'd1,
        MD_PDOWN  = 2'd2,
        MD_SETTLE = 2'd3
    } pwr_mode_e;

    localparam int unsigned CYCLE_STATES = 6;
    localparam int unsigned STATE_W      = $clog2(CYCLE_STATES + 1);

endpackage

// File: rtl/mcpc_seq.sv
module mcpc_seq #(
    parameter int unsigned N_STATES = 6,
    localparam int unsigned SW = $clog2(N_STATES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          park,
    output logic [SW-1:0] st_idx,
    output logic          ph2,
    output logic          last
);

    localparam logic [SW-1:0] LAST_IDX = SW'(N_STATES - 1);

    typedef struct packed {
        logic [SW-1:0] st;
        logic          ph;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (park) begin
            seq_d.st = '0;
            seq_d.ph = 1'b0;
        end else if (advance) begin
            if (!seq_q.ph) begin
                seq_d.ph = 1'b1;
            end else begin
                seq_d.ph = 1'b0;
                seq_d.st = (seq_q.st == LAST_IDX) ? '0 : seq_q.st + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st_idx = seq_q.st;
    assign ph2    = seq_q.ph;
    assign last   = (seq_q.st == LAST_IDX) && seq_q.ph;

    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st <= LAST_IDX); // R2

    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !park) |=> (seq_q.ph != $past(seq_q.ph))); // R2

    AST_STATE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !park && last) |=> (seq_q.st == '0)); // R2

endmodule

// File: rtl/mcpc_wake.sv
module mcpc_wake #(
    parameter int unsigned N_EXT = 2
) (
    input  logic [N_EXT-1:0] ext_irq,
    input  logic             rtc_irq,
    input  logic             periph_irq,
    output logic             pd_wake,
    output logic             idle_wake
);

    // Only sources that remain alive with the oscillator stopped may end power-down
    always_comb begin
        pd_wake   = (|ext_irq) | rtc_irq;
        idle_wake = pd_wake | periph_irq;
    end

endmodule

// File: rtl/mcpc_mode.sv
module mcpc_mode
    import mcpc_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 16,
    localparam int unsigned CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      set_idle,
    input  logic      set_pdown,
    input  logic      cyc_last,
    input  logic      pd_wake,
    input  logic      idle_wake,
    output pwr_mode_e mode
);

    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        pwr_mode_e     mode;
        logic          pend_idle;
        logic          pend_pd;
        logic          wake_seen;
        logic [CW-1:0] cnt;
    } mode_t;

    mode_t m_d, m_q;

    logic want_idle, want_pd, idle_exit;

    always_comb begin
        m_d       = m_q;
        want_idle = m_q.pend_idle | set_idle;
        want_pd   = m_q.pend_pd | set_pdown;
        idle_exit = m_q.wake_seen | idle_wake;

        unique case (m_q.mode)
            MD_RUN: begin
                if (cyc_last) begin
                    m_d.pend_idle = 1'b0;
                    m_d.pend_pd   = 1'b0;
                    m_d.wake_seen = 1'b0;
                    if (want_pd) begin
                        m_d.mode = MD_PDOWN;
                    end else if (want_idle) begin
                        m_d.mode = MD_IDLE;
                    end
                end else begin
                    m_d.pend_idle = want_idle;
                    m_d.pend_pd   = want_pd;
                end
            end
            MD_IDLE: begin
                if (cyc_last && idle_exit) begin
                    m_d.mode      = MD_RUN;
                    m_d.wake_seen = 1'b0;
                end else begin
                    m_d.wake_seen = idle_exit;
                end
            end
            MD_PDOWN: begin
                m_d.cnt = '0;
                if (pd_wake) begin
                    m_d.mode = MD_SETTLE;
                end
            end
            MD_SETTLE: begin
                if (m_q.cnt == CNT_LAST) begin
                    m_d.mode = MD_RUN;
                    m_d.cnt  = '0;
                end else begin
                    m_d.cnt = m_q.cnt + 1'b1;
                end
            end
            default: m_d.mode = MD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{mode: MD_RUN, pend_idle: 1'b0, pend_pd: 1'b0,
                     wake_seen: 1'b0, cnt: '0};
        end else begin
            m_q <= m_d;
        end
    end

    assign mode = m_q.mode;

    AST_RUN_LEAVES_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.mode == MD_RUN && !cyc_last) |=> (m_q.mode == MD_RUN)); // R4

    AST_IDLE_LEAVES_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.mode == MD_IDLE && !cyc_last) |=> (m_q.mode == MD_IDLE)); // R6

    AST_PD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.mode == MD_RUN && cyc_last && want_pd && want_idle) |=> (m_q.mode == MD_PDOWN)); // R9

    AST_PD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.mode == MD_PDOWN && !pd_wake) |=> (m_q.mode == MD_PDOWN)); // R7

    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.cnt <= CNT_LAST); // R8

endmodule

// File: rtl/mcpc_top.sv
module mcpc_top
    import mcpc_pkg::*;
#(
    parameter int unsigned N_EXT      = 2,
    parameter int unsigned SETTLE_CYC = 16
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             set_idle,
    input  logic             set_pdown,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic             rtc_irq,
    input  logic             periph_irq,
    output logic [2:0]       state_num,
    output logic             phase2,
    output logic             cycle_end,
    output logic             cpu_en,
    output logic             periph_en,
    output logic             osc_run
);

    logic [STATE_W-1:0] st_idx;
    logic               seq_last;
    logic               seq_adv;
    logic               seq_park;
    logic               pd_wake;
    logic               idle_wake;
    pwr_mode_e          mode;

    always_comb begin
        seq_adv  = (mode == MD_RUN) || (mode == MD_IDLE);
        seq_park = (mode == MD_PDOWN) || (mode == MD_SETTLE);
    end

    mcpc_seq #(
        .N_STATES (CYCLE_STATES)
    ) u_seq (
        .clk     (clk_osc),
        .rst_n   (rst_n),
        .advance (seq_adv),
        .park    (seq_park),
        .st_idx  (st_idx),
        .ph2     (phase2),
        .last    (seq_last)
    );

    mcpc_wake #(
        .N_EXT (N_EXT)
    ) u_wake (
        .ext_irq    (ext_irq),
        .rtc_irq    (rtc_irq),
        .periph_irq (periph_irq),
        .pd_wake    (pd_wake),
        .idle_wake  (idle_wake)
    );

    mcpc_mode #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_mode (
        .clk       (clk_osc),
        .rst_n     (rst_n),
        .set_idle  (set_idle),
        .set_pdown (set_pdown),
        .cyc_last  (seq_last),
        .pd_wake   (pd_wake),
        .idle_wake (idle_wake),
        .mode      (mode)
    );

    always_comb begin
        state_num = 3'(st_idx) + 3'd1;
        cpu_en    = (mode == MD_RUN);
        periph_en = (mode == MD_RUN) || (mode == MD_IDLE);
        osc_run   = (mode != MD_PDOWN);
        cycle_end = seq_last && (mode == MD_RUN);
    end

    AST_END_ONE_WIDE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cycle_end |=> !cycle_end); // R3

    AST_END_IN_S6P2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cycle_end |-> (state_num == 3'd6 && phase2 && cpu_en)); // R3

    AST_STOPPED_AT_S1: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !osc_run |-> (state_num == 3'd1 && !phase2 && !periph_en)); // R7

    AST_CPU_RESUMES_S1: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(cpu_en) |-> (state_num == 3'd1 && !phase2)); // R6

endmodule

// File: tb/tb_mcpc_top.sv
module tb_mcpc_top;

    localparam int PERIOD = 10;
    localparam int SETTLE = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_idle = 1'b0;
    logic       set_pdown = 1'b0;
    logic [1:0] ext_irq = 2'b00;
    logic       rtc_irq = 1'b0;
    logic       periph_irq = 1'b0;
    logic [2:0] state_num;
    logic       phase2, cycle_end, cpu_en, periph_en, osc_run;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    mcpc_top #(.N_EXT(2), .SETTLE_CYC(SETTLE)) dut (
        .clk_osc(clk), .rst_n(rst_n), .set_idle(set_idle), .set_pdown(set_pdown),
        .ext_irq(ext_irq), .rtc_irq(rtc_irq), .periph_irq(periph_irq),
        .state_num(state_num), .phase2(phase2), .cycle_end(cycle_end),
        .cpu_en(cpu_en), .periph_en(periph_en), .osc_run(osc_run)
    );

    // Behavioural reference: position 0..11 within a machine cycle,
    // mode 0 run, 1 idle, 2 power-down, 3 settling
    int m_pos = 0, m_md = 0, m_scnt = 0;
    bit m_pi = 0, m_pp = 0, m_wk = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = 0; m_md = 0; m_scnt = 0; m_pi = 0; m_pp = 0; m_wk = 0;
        end else begin
            automatic bit any_pd = (ext_irq != 2'b00) || rtc_irq;
            automatic bit any_i  = any_pd || periph_irq;
            case (m_md)
                0: begin
                    m_pi = m_pi | set_idle;
                    m_pp = m_pp | set_pdown;
                    if (m_pos == 11) begin
                        m_pos = 0;
                        if (m_pp) m_md = 2;
                        else if (m_pi) m_md = 1;
                        m_pi = 0; m_pp = 0; m_wk = 0;
                    end else m_pos++;
                end
                1: begin
                    if (m_pos == 11) begin
                        m_pos = 0;
                        if (m_wk || any_i) begin m_md = 0; m_wk = 0; end
                    end else begin
                        m_pos++;
                        m_wk = m_wk | any_i;
                    end
                end
                2: begin
                    m_pos = 0; m_scnt = 0;
                    if (any_pd) m_md = 3;
                end
                default: begin
                    m_pos = 0;
                    if (m_scnt == SETTLE - 1) begin m_md = 0; m_scnt = 0; end
                    else m_scnt++;
                end
            endcase
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int  e_st  = m_pos / 2 + 1;
            automatic bit  e_ph  = m_pos % 2;
            automatic bit  e_cpu = (m_md == 0);
            automatic bit  e_per = (m_md <= 1);
            automatic bit  e_osc = (m_md != 2);
            automatic bit  e_end = (m_md == 0) && (m_pos == 11);
            automatic string tag;
            n_tests++;
            case (m_md)
                0: tag = (cycle_end != e_end) ? "R3" : "R2";
                1: tag = "R5";
                2: tag = "R7";
                default: tag = "R8";
            endcase
            if (state_num != e_st || phase2 != e_ph || cpu_en != e_cpu ||
                periph_en != e_per || osc_run != e_osc || cycle_end != e_end) begin
                n_fail++;
                $display("FAIL %s model: actual st=%0d ph=%0d end=%0d cpu=%0d per=%0d osc=%0d expected st=%0d ph=%0d end=%0d cpu=%0d per=%0d osc=%0d",
                         tag, state_num, phase2, cycle_end, cpu_en, periph_en, osc_run,
                         e_st, e_ph, e_end, e_cpu, e_per, e_osc);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_pos(input int s, input bit p);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (state_num == 3'(s) && phase2 == p) break;
        end
    endtask

    task automatic enter_idle();
        wait_pos(2, 0);
        set_idle = 1'b1;
        @(negedge clk);
        set_idle = 1'b0;
        wait_pos(6, 1);
        @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        check(state_num == 3'd1 && !phase2, tag, state_num, 1);
        check(cpu_en && periph_en && osc_run && !cycle_end, tag,
              {cpu_en, periph_en, osc_run, cycle_end}, 4'b1110);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1 during reset");
        rst_n = 1'b1;
        check_reset_state("R1 after release");

        // R2, R3: free running, checked by the model every clock
        repeat (30) @(negedge clk);

        // R4: request in mid cycle waits for the boundary
        wait_pos(3, 0);
        set_idle = 1'b1;
        @(negedge clk);
        set_idle = 1'b0;
        wait_pos(6, 1);
        check(cpu_en == 1'b1, "R4 request deferred", cpu_en, 1);
        @(negedge clk);
        check(cpu_en == 1'b0, "R5 idle cpu off", cpu_en, 0);
        check(periph_en == 1'b1 && osc_run == 1'b1, "R5 idle periph on", periph_en, 1);

        // R4: power-down request during idle is ignored; R6 wake by peripheral
        wait_pos(3, 0);
        set_pdown = 1'b1;
        @(negedge clk);
        set_pdown = 1'b0;
        repeat (10) @(negedge clk);
        wait_pos(2, 0);
        periph_irq = 1'b1;
        @(negedge clk);
        periph_irq = 1'b0;
        wait_pos(6, 1);
        check(cpu_en == 1'b0, "R6 still idle before boundary", cpu_en, 0);
        @(negedge clk);
        check(cpu_en == 1'b1 && state_num == 3'd1 && !phase2, "R6 resume at S1",
              {cpu_en, state_num, phase2}, {1'b1, 3'd1, 1'b0});
        repeat (24) @(negedge clk);
        check(cpu_en == 1'b1 && osc_run == 1'b1, "R4 ignored request left no trace",
              {cpu_en, osc_run}, 2'b11);

        // R6: wake sampled on the boundary edge itself
        enter_idle();
        check(cpu_en == 1'b0, "R5 idle again", cpu_en, 0);
        wait_pos(6, 1);
        ext_irq = 2'b01;
        @(negedge clk);
        ext_irq = 2'b00;
        check(cpu_en == 1'b1 && state_num == 3'd1, "R6 wake on boundary", cpu_en, 1);

        // R4: request on the S6 phase-2 edge; R7 power-down
        wait_pos(6, 1);
        set_pdown = 1'b1;
        @(negedge clk);
        set_pdown = 1'b0;
        check(osc_run == 1'b0, "R4 boundary request", osc_run, 0);
        check(!cpu_en && !periph_en && state_num == 3'd1 && !phase2, "R7 stopped",
              {cpu_en, periph_en, state_num, phase2}, 6'b000010);
        periph_irq = 1'b1;
        @(negedge clk);
        periph_irq = 1'b0;
        repeat (5) @(negedge clk);
        check(osc_run == 1'b0, "R7 periph irq ignored", osc_run, 0);

        // R8: settle length after RTC wake
        rtc_irq = 1'b1;
        @(negedge clk);
        rtc_irq = 1'b0;
        begin
            int cnt = 0;
            for (int i = 0; i < 100 && !cpu_en; i++) begin
                if (osc_run && !periph_en) cnt++;
                @(negedge clk);
            end
            check(cnt == SETTLE, "R8 settle length", cnt, SETTLE);
        end
        check(cpu_en && state_num == 3'd1 && !phase2, "R8 restart at S1",
              {cpu_en, state_num}, {1'b1, 3'd1});

        // R9: both requests together
        wait_pos(4, 1);
        set_idle = 1'b1;
        set_pdown = 1'b1;
        @(negedge clk);
        set_idle = 1'b0;
        set_pdown = 1'b0;
        wait_pos(6, 1);
        @(negedge clk);
        check(osc_run == 1'b0 && periph_en == 1'b0, "R9 power-down priority",
              {osc_run, periph_en}, 2'b00);
        ext_irq = 2'b10;
        @(negedge clk);
        ext_irq = 2'b00;
        repeat (SETTLE + 2) @(negedge clk);
        check(cpu_en == 1'b1, "R8 wake by second external line", cpu_en, 1);

        // R10: reset out of idle and out of power-down
        enter_idle();
        wait_pos(4, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R10 reset from idle");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        wait_pos(6, 1);
        set_pdown = 1'b1;
        @(negedge clk);
        set_pdown = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R10 reset from power-down");
        rst_n = 1'b1;
        repeat (30) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule